// File: doc/BRIEF.md
# Aging Priority Memory Arbiter

This block picks which of several bus masters may next use a shared external SDRAM controller. Each master presents a request together with the kind of transfer it wants (read or write) and the SDRAM bank it will hit. The arbiter hands out a single grant and keeps it on that master until the master reports that its transfer has finished. The choice of the next master is already made while the current transfer runs, so a waiting master takes over on the same clock edge that ends the previous grant.

The ranking starts from a fixed base order chosen at build time. Three things adjust it at run time. First, a per-master aging counter raises the level of a master that has waited longer than its software-written limit. Second, requests of the same kind as the last granted transfer get a bonus, which keeps reads and writes grouped. Third, requests to a bank other than the one still inside its turnaround window get a bonus, so that bank accesses can interleave. A master's aging state is cleared when it wins.

Top module: `mem_age_arbiter`

## Requirements
- R1: After reset no grant is active, every aging level is 0, every aging limit holds its all-ones value, the last transfer kind counts as read and no bank is busy.
- R2: At most one grant bit is high at any time, a grant goes only to a master whose request is high, and an idle arbiter grants a requester on the first clock edge that sees the request.
- R3: A grant stays on its master until that master's `done_i` bit is high at a clock edge; `done_i` bits of other masters have no effect.
- R4: On the edge where the owner's done is seen, the best other requester gets the grant at once with no idle cycle; with no other requester the grant drops.
- R5: Each requester scores min(base + aging level, 15) + kind bonus (3) + bank bonus (2), where master i has base level N_MST-1-i (master 0 highest); the highest score wins and equal scores go to the lower index.
- R6: The kind bonus is given when a request's `wr_i` bit (1 = write, 0 = read) equals that of the last granted transfer.
- R7: The bank bonus is given unless the request targets the bank of the last granted transfer while fewer than 12 cycles have passed since that grant.
- R8: Writing `cfg_limit_i` with `cfg_we_i` high sets the aging limit of master `cfg_idx_i`; every clock edge where a master waits (requests without holding the grant) its wait count rises, and when the count equals the limit the count returns to 0 and the aging level rises by one, i.e. one level per limit+1 waiting cycles.
- R9: The aging level saturates at 15 and never wraps to a smaller value.
- R10: Winning a grant clears the winner's wait count and aging level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MST | Request, one bit per master |
| wr_i | input | N_MST | Transfer kind per master: 1 write, 0 read |
| bank_i | input | N_MST*BANK_W | Target bank per master, master i at bits [i*BANK_W +: BANK_W] |
| done_i | input | N_MST | Transfer finished, one bit per master |
| cfg_we_i | input | 1 | Aging limit write strobe |
| cfg_idx_i | input | IDX_W | Master whose limit is written |
| cfg_limit_i | input | CNT_W | Aging limit value |
| gnt_o | output | N_MST | One-hot grant |

## Verification
Requests are offered one at a time to show the grant latency and the hold until done, then in groups of equal kind and free banks so that the base order alone decides. Groups that differ only in transfer kind, or only in whether the bank lies inside the turnaround window (before and after it expires), separate the kind and bank bonuses from the base order. Long waits with small limits show aging overtaking the base order, the level saturating instead of wrapping, and the level being cleared by a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Base level of a master: index 0 ranks highest.
  function automatic int unsigned arb_base_level(int unsigned idx, int unsigned n);
    return n - 1 - idx;
  endfunction

  // Score of one requester: capped aged level plus preference bonuses.
  function automatic int unsigned arb_score(int unsigned base, int unsigned boost,
                                            int unsigned max_lvl, bit same_kind,
                                            bit bank_free, int unsigned kind_bonus,
                                            int unsigned bank_bonus);
    int unsigned lvl;
    lvl = base + boost;
    if (lvl > max_lvl) lvl = max_lvl;
    return lvl + (same_kind ? kind_bonus : 0) + (bank_free ? bank_bonus : 0);
  endfunction

endpackage

// File: rtl/arb_age_cell.sv
module arb_age_cell #(
  parameter int LVL_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             limit_we,
  input  logic [CNT_W-1:0] limit_d,
  input  logic             waiting,
  input  logic             granted,
  output logic [LVL_W-1:0] boost_o
);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0] boost_q;
  logic             bump;

  assign bump    = waiting && !granted && (cnt_q == limit_q);
  assign boost_o = boost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '1;
    end else if (limit_we) begin
      limit_q <= limit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      boost_q <= '0;
    end else if (granted) begin
      cnt_q   <= '0;
      boost_q <= '0;
    end else if (bump) begin
      cnt_q   <= '0;
      boost_q <= (boost_q == MAX_LVL) ? boost_q : boost_q + 1'b1;
    end else if (waiting) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R10: a grant clears the level
  a_r10_clear_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    granted |=> (boost_o == '0));
  // R8: a bump below the cap raises the level by exactly one
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && boost_o != MAX_LVL) |=> (boost_o == $past(boost_o) + 1'b1));
  // R9: the cap holds without a grant
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_o == MAX_LVL && !granted) |=> (boost_o == MAX_LVL));
  // R8: without a bump or grant the level does not move
  a_r8_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !granted) |=> $stable(boost_o));

endmodule

// File: rtl/arb_bank_track.sv
module arb_bank_track #(
  parameter int BANK_W   = 2,
  parameter int TURN_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              win_wr,
  input  logic [BANK_W-1:0] win_bank,
  output logic              last_wr_o,
  output logic              busy_o,
  output logic [BANK_W-1:0] busy_bank_o
);
  localparam int TMR_W = $clog2(TURN_CYC + 1);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr_o   <= 1'b0;
      busy_bank_o <= '0;
      tmr_q       <= '0;
    end else if (issue) begin
      last_wr_o   <= win_wr;
      busy_bank_o <= win_bank;
      tmr_q       <= TMR_W'(TURN_CYC);
    end else if (tmr_q != '0) begin
      tmr_q       <= tmr_q - 1'b1;
    end
  end

  assign busy_o = (tmr_q != '0);

  // R6: the last kind follows the issued transfer
  a_r6_kind_follows: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (last_wr_o == $past(win_wr)));
  // R7: an issue opens the turnaround window on its bank
  a_r7_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (busy_o && busy_bank_o == $past(win_bank)));

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int N_MST      = 6,
  parameter int BANK_W     = 2,
  parameter int LVL_W      = 4,
  parameter int KIND_BONUS = 3,
  parameter int BANK_BONUS = 2,
  localparam int IDX_W     = $clog2(N_MST),
  localparam int SCORE_W   = LVL_W + 3
) (
  input  logic [N_MST-1:0]        cand_i,
  input  logic [N_MST-1:0]        wr_i,
  input  logic [N_MST*BANK_W-1:0] bank_i,
  input  logic [N_MST*LVL_W-1:0]  boost_i,
  input  logic                    last_wr_i,
  input  logic                    busy_i,
  input  logic [BANK_W-1:0]       busy_bank_i,
  output logic                    win_valid_o,
  output logic [IDX_W-1:0]        win_idx_o
);
  localparam int unsigned MAX_LVL = (1 << LVL_W) - 1;

  logic [SCORE_W-1:0] score [N_MST];

  for (genvar g = 0; g < N_MST; g++) begin : g_score
    logic same_kind;
    logic bank_free;
    assign same_kind = (wr_i[g] == last_wr_i);
    assign bank_free = !busy_i || (bank_i[g*BANK_W +: BANK_W] != busy_bank_i);
    assign score[g]  = SCORE_W'(arb_score(arb_base_level(g, N_MST),
                                          int'(boost_i[g*LVL_W +: LVL_W]),
                                          MAX_LVL, same_kind, bank_free,
                                          KIND_BONUS, BANK_BONUS));
  end

  always_comb begin
    logic [SCORE_W-1:0] best;
    best        = '0;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (cand_i[i] && (!win_valid_o || score[i] > best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best        = score[i];
      end
    end
  end

endmodule

// File: rtl/mem_age_arbiter.sv
module mem_age_arbiter #(
  parameter int N_MST      = 6,
  parameter int BANK_W     = 2,
  parameter int LVL_W      = 4,
  parameter int CNT_W      = 8,
  parameter int TURN_CYC   = 12,
  parameter int KIND_BONUS = 3,
  parameter int BANK_BONUS = 2,
  localparam int IDX_W     = $clog2(N_MST)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST-1:0]        wr_i,
  input  logic [N_MST*BANK_W-1:0] bank_i,
  input  logic [N_MST-1:0]        done_i,
  input  logic                    cfg_we_i,
  input  logic [IDX_W-1:0]        cfg_idx_i,
  input  logic [CNT_W-1:0]        cfg_limit_i,
  output logic [N_MST-1:0]        gnt_o
);
  logic                    active_q;
  logic [IDX_W-1:0]        owner_q;
  logic [N_MST-1:0]        own_oh;
  logic                    release_ev;
  logic                    can_issue;
  logic                    issue_ev;
  logic [N_MST-1:0]        cand;
  logic                    win_valid;
  logic [IDX_W-1:0]        win_idx;
  logic [N_MST*LVL_W-1:0]  boost_all;
  logic                    last_wr;
  logic                    busy;
  logic [BANK_W-1:0]       busy_bank;

  assign own_oh     = active_q ? (N_MST'(1) << owner_q) : '0;
  assign gnt_o      = own_oh;
  assign release_ev = active_q && done_i[owner_q];
  assign can_issue  = !active_q || release_ev;
  assign cand       = req_i & ~own_oh;
  assign issue_ev   = can_issue && win_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      owner_q  <= '0;
    end else if (issue_ev) begin
      active_q <= 1'b1;
      owner_q  <= win_idx;
    end else if (release_ev) begin
      active_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_age
    arb_age_cell #(.LVL_W(LVL_W), .CNT_W(CNT_W)) i_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .limit_we (cfg_we_i && cfg_idx_i == IDX_W'(g)),
      .limit_d  (cfg_limit_i),
      .waiting  (req_i[g] && !own_oh[g]),
      .granted  (issue_ev && win_idx == IDX_W'(g)),
      .boost_o  (boost_all[g*LVL_W +: LVL_W])
    );
  end

  arb_bank_track #(.BANK_W(BANK_W), .TURN_CYC(TURN_CYC)) i_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue_ev),
    .win_wr      (wr_i[win_idx]),
    .win_bank    (bank_i[win_idx*BANK_W +: BANK_W]),
    .last_wr_o   (last_wr),
    .busy_o      (busy),
    .busy_bank_o (busy_bank)
  );

  arb_pick #(
    .N_MST(N_MST), .BANK_W(BANK_W), .LVL_W(LVL_W),
    .KIND_BONUS(KIND_BONUS), .BANK_BONUS(BANK_BONUS)
  ) i_pick (
    .cand_i      (cand),
    .wr_i        (wr_i),
    .bank_i      (bank_i),
    .boost_i     (boost_all),
    .last_wr_i   (last_wr),
    .busy_i      (busy),
    .busy_bank_i (busy_bank),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  // R2: never more than one grant
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  // R2: an issued grant belongs to a requester
  a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ev |-> req_i[win_idx]);
  // R3: without the owner's done the grant is held
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_o) && !(|(gnt_o & done_i))) |=> $stable(gnt_o));
  // R4: owner done with others waiting hands over without a gap
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt_o & done_i)) && (|(req_i & ~gnt_o))) |=> ((|gnt_o) && gnt_o != $past(gnt_o)));

endmodule

// File: tb/test_mem_age_arbiter.sv
module test_mem_age_arbiter;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] wr = '0;
  logic [2*N-1:0] bank = '0;
  logic [N-1:0] done = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_idx = '0;
  logic [7:0]   cfg_limit = '0;
  logic [N-1:0] gnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mem_age_arbiter i_mem_age_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .bank_i(bank),
    .done_i(done), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_limit_i(cfg_limit), .gnt_o(gnt)
  );

  task automatic chk(input logic [N-1:0] exp, input string tag);
    checks++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%b expected %b", tag, gnt, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int m, input logic r, input logic w, input logic [1:0] b);
    req[m] = r;
    wr[m] = w;
    bank[m*2 +: 2] = b;
  endtask

  // owner m finishes and withdraws; returns one edge later
  task automatic finish_m(input int m);
    done[m] = 1'b1;
    req[m] = 1'b0;
    @(negedge clk);
    done[m] = 1'b0;
  endtask

  task automatic set_limit(input int m, input logic [7:0] v);
    cfg_we = 1'b1; cfg_idx = 3'(m); cfg_limit = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick(3);
    chk('0, "R1 no grant in reset");
    rst_n = 1'b1;
    tick(1);
    chk('0, "R1 no grant after reset");
  endtask

  task automatic t_single;
    put(2, 1, 0, 1);
    tick(1);
    chk(6'b000100, "R2 single request granted next edge");
    done[3] = 1'b1;
    tick(1);
    done[3] = 1'b0;
    chk(6'b000100, "R3 foreign done ignored");
    tick(3);
    chk(6'b000100, "R3 grant held without done");
    finish_m(2);
    chk('0, "R4 grant drops with no other requester");
  endtask

  task automatic t_order;
    put(1, 1, 0, 0); put(3, 1, 0, 2); put(5, 1, 0, 3);
    tick(1);
    chk(6'b000010, "R5 base order picks master 1");
    tick(2);
    finish_m(1);
    chk(6'b001000, "R4 back-to-back handover to master 3");
    finish_m(3);
    chk(6'b100000, "R5 last requester master 5");
    finish_m(5);
    chk('0, "R4 idle after last release");
  endtask

  task automatic t_kind;
    put(4, 1, 1, 1);
    tick(1);
    chk(6'b010000, "R2 write alone granted");
    finish_m(4);
    put(3, 1, 1, 0); put(2, 1, 0, 2);
    tick(1);
    chk(6'b001000, "R6 write after write beats higher base read");
    finish_m(3);
    chk(6'b000100, "R6 read served next");
    finish_m(2);
    put(1, 1, 1, 0); put(3, 1, 0, 1);
    tick(1);
    chk(6'b001000, "R6 read after read beats higher base write");
    finish_m(3);
    chk(6'b000010, "R6 write served next");
    finish_m(1);
  endtask

  task automatic t_bank;
    put(0, 1, 0, 2);
    tick(1);
    chk(6'b000001, "R2 master 0 alone");
    put(1, 1, 0, 2); put(2, 1, 0, 1);
    tick(1);
    finish_m(0);
    chk(6'b000100, "R7 other bank wins inside turnaround");
    finish_m(2);
    chk(6'b000010, "R7 same-bank master served next");
    finish_m(1);
    put(0, 1, 0, 2);
    tick(1);
    chk(6'b000001, "R2 master 0 alone again");
    put(1, 1, 0, 2); put(2, 1, 0, 1);
    tick(16);
    finish_m(0);
    chk(6'b000010, "R7 window expired, base order again");
    finish_m(1);
    chk(6'b000100, "R7 remaining master");
    finish_m(2);
  endtask

  task automatic t_aging;
    set_limit(5, 8'd2);
    put(1, 1, 0, 0);
    tick(1);
    chk(6'b000010, "R8 holder master 1");
    put(0, 1, 0, 1); put(5, 1, 0, 2);
    tick(6);
    finish_m(1);
    chk(6'b000001, "R8 short wait: aging not yet enough");
    put(1, 1, 0, 0);
    tick(30);
    finish_m(0);
    chk(6'b100000, "R8 long wait: aged master 5 overtakes");
    finish_m(5);
    chk(6'b000010, "R8 master 1 next");
    finish_m(1);
  endtask

  task automatic t_saturate;
    set_limit(5, 8'd0);
    put(1, 1, 0, 0);
    tick(1);
    chk(6'b000010, "R9 holder master 1");
    put(0, 1, 0, 1); put(5, 1, 0, 2);
    tick(36);
    finish_m(1);
    chk(6'b100000, "R9 level saturated, no wrap");
    finish_m(5);
    chk(6'b000001, "R9 master 0 next");
    finish_m(0);
  endtask

  task automatic t_clear;
    put(5, 1, 0, 2); put(4, 1, 0, 3);
    tick(1);
    chk(6'b010000, "R10 cleared level: master 4 wins");
    finish_m(4);
    chk(6'b100000, "R10 master 5 next");
    finish_m(5);
    chk('0, "R10 idle at end");
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_single;
    t_order;
    t_kind;
    t_bank;
    t_aging;
    t_saturate;
    t_clear;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule